// File: doc/BRIEF.md
# Glitch-Filtered Rising-Crossing Time Tagger

This block takes the one-bit output of a flip-flop that samples a noisy beat signal on a slightly offset clock. Near each zero-crossing of the beat, the sampled bit chatters for a while before it settles. The block turns each rising burst into one time tag. The tag is the value of a free-running 32-bit cycle counter in the offset-clock domain. Everything runs in that one clock domain.

The raw bit passes through a short synchronizer and then into a detector. The detector arms only after a run of stable low samples. The first one after that opens a crossing window. Inside the window the detector keeps saturating tallies of ones and zeros. It declares the crossing at the first one-sample where the ones tally is greater than the zeros tally. The comparison is held back until at least one zero has been counted, because the opening one would otherwise win the vote at once. If a long run of consecutive ones arrives, the detector treats the input as settled high and declares the crossing at once. After a crossing, the detector requires a stable high run and then a stable low run before it can arm again, so falling bursts never give a tag.

A consumer reads the tags on a single-cycle strobe and handles counter wrap itself.

Top module: `beat_crossing_tagger`

## Requirements
- R1: While reset is asserted and right after it is released, `tagValid` is 0, `tagData` is 0 and the detector is unarmed.
- R2: The detector arms only after `STABLE_LEN` (default 16) consecutive low samples. A one that arrives before that run is complete clears the run and produces no tag.
- R3: Once armed, the first one-sample opens a window with ones = 1 and zeros = 0. The vote is not taken until at least one zero has been counted. The crossing is then declared at the first one-sample where the incremented ones tally is greater than the zeros tally.
- R4: When `NO_GLITCH_ONES` (default 32) consecutive ones have been sampled inside the window, counting the opening one or counting from the last zero, the crossing is declared at that sample whatever the vote says.
- R5: The tag equals the cycle-counter value during the cycle in which the deciding raw bit was presented on `beatIn`. `tagValid` rises 3 cycles after that cycle: `SYNC_STAGES` = 2 plus one output register.
- R6: `tagValid` is high for exactly one cycle per crossing. `tagData` holds its last value while `tagValid` is low.
- R7: After a crossing, the detector re-arms only after `STABLE_LEN` consecutive ones followed by `STABLE_LEN` consecutive zeros. Falling bursts and short low runs produce no tag.
- R8: The ones and zeros tallies saturate at 2^`TALLY_W`-1 (default 255) and do not wrap. With 270 zeros in a window, the vote cannot be won by fewer than 255 ones, so the ones-run limit decides.
- R9: The cycle counter is 0 in the first cycle after reset release and increments by 1 every cycle, wrapping modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Offset sampling clock; the only clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| beatIn | input | 1 | Raw flip-flop output of the beat signal |
| tagValid | output | 1 | One-cycle strobe marking a new tag |
| tagData | output | 32 | Cycle-counter time tag of the declared crossing |

## Verification
A raw bit driven in cycle c moves through two synchronizer flops and is seen by the detector in cycle c+2. The decision is registered, so a tag carrying the value c appears in cycle c+3. The bench drives one bit per cycle on the falling edge, starting in the cycle reset is released, and records every strobe on later falling edges. Each scenario ends with idle cycles that are longer than the three-cycle latency, so tag counts and values are compared only after every pending tag has had time to appear. Expected tags are cycle indices counted by hand from each pattern.

// File: rtl/bct_pkg.sv
package bct_pkg;

  typedef enum logic [1:0] {
    ST_UNARMED,
    ST_ARMED,
    ST_WINDOW,
    ST_HIGHQ
  } detState_t;

  typedef struct packed {
    logic runInc;
    logic runClr;
    logic tallyOpen;
    logic tallyOne;
    logic tallyZero;
    logic emit;
  } strobe_t;

  typedef struct packed {
    logic runFull;
    logic voteWin;
    logic limitHit;
  } status_t;

endpackage

// File: rtl/bct_sync.sv
module bct_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dIn,
  output logic dOut
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= dIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dOut = chain[STAGES-1];
endmodule

// File: rtl/bct_ctrl.sv
module bct_ctrl
  import bct_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sample,
  input  status_t   stat,
  output strobe_t   strobe,
  output detState_t state
);
  detState_t nextState;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_UNARMED;
    else        state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_UNARMED: begin
        if (sample) begin
          strobe.runClr = 1'b1;
        end else if (stat.runFull) begin
          strobe.runClr = 1'b1;
          nextState     = ST_ARMED;
        end else begin
          strobe.runInc = 1'b1;
        end
      end
      ST_ARMED: begin
        if (sample) begin
          strobe.tallyOpen = 1'b1;
          nextState        = ST_WINDOW;
        end
      end
      ST_WINDOW: begin
        if (sample) begin
          if (stat.voteWin || stat.limitHit) begin
            strobe.emit   = 1'b1;
            strobe.runClr = 1'b1;
            nextState     = ST_HIGHQ;
          end else begin
            strobe.tallyOne = 1'b1;
          end
        end else begin
          strobe.tallyZero = 1'b1;
        end
      end
      ST_HIGHQ: begin
        if (!sample) begin
          strobe.runClr = 1'b1;
        end else if (stat.runFull) begin
          strobe.runClr = 1'b1;
          nextState     = ST_UNARMED;
        end else begin
          strobe.runInc = 1'b1;
        end
      end
      default: nextState = ST_UNARMED;
    endcase
  end
endmodule

// File: rtl/bct_datapath.sv
module bct_datapath
  import bct_pkg::*;
#(
  parameter int STABLE_LEN     = 16,
  parameter int NO_GLITCH_ONES = 32,
  parameter int TALLY_W        = 8,
  parameter int TAG_W          = 32,
  parameter int SYNC_STAGES    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          strobe,
  output status_t          stat,
  output logic             tagValid,
  output logic [TAG_W-1:0] tagData
);
  localparam int RUN_W = $clog2(STABLE_LEN + 1);
  localparam int OR_W  = $clog2(NO_GLITCH_ONES + 1);
  localparam logic [RUN_W:0]       RUN_TARGET = (RUN_W+1)'(STABLE_LEN);
  localparam logic [OR_W:0]        OR_TARGET  = (OR_W+1)'(NO_GLITCH_ONES);
  localparam logic [RUN_W-1:0]     RUN_MAX    = '1;
  localparam logic [OR_W-1:0]      OR_MAX     = '1;
  localparam logic [TALLY_W-1:0]   TALLY_MAX  = '1;
  localparam logic [TAG_W-1:0]     LATENCY    = TAG_W'(SYNC_STAGES);

  logic [RUN_W-1:0]   runCnt;
  logic [OR_W-1:0]    onesRun;
  logic [TALLY_W-1:0] onesTally;
  logic [TALLY_W-1:0] zerosTally;
  logic               seenZero;
  logic [TAG_W-1:0]   cycleCount;

  logic [RUN_W:0]     runNext;
  logic [OR_W:0]      onesRunNext;
  logic [TALLY_W-1:0] onesBump;
  logic [TALLY_W-1:0] zerosBump;

  assign runNext     = {1'b0, runCnt} + {{RUN_W{1'b0}}, 1'b1};
  assign onesRunNext = {1'b0, onesRun} + {{OR_W{1'b0}}, 1'b1};
  assign onesBump    = (onesTally == TALLY_MAX) ? onesTally : onesTally + 1'b1;
  assign zerosBump   = (zerosTally == TALLY_MAX) ? zerosTally : zerosTally + 1'b1;

  assign stat.runFull  = (runNext >= RUN_TARGET);
  assign stat.limitHit = (onesRunNext >= OR_TARGET);
  assign stat.voteWin  = seenZero && (onesBump > zerosTally);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cycleCount <= '0;
    else        cycleCount <= cycleCount + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runCnt <= '0;
    end else if (strobe.runClr) begin
      runCnt <= '0;
    end else if (strobe.runInc && runCnt != RUN_MAX) begin
      runCnt <= runCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      onesTally  <= '0;
      zerosTally <= '0;
      onesRun    <= '0;
      seenZero   <= 1'b0;
    end else if (strobe.tallyOpen) begin
      onesTally  <= {{(TALLY_W-1){1'b0}}, 1'b1};
      zerosTally <= '0;
      onesRun    <= {{(OR_W-1){1'b0}}, 1'b1};
      seenZero   <= 1'b0;
    end else if (strobe.tallyOne) begin
      onesTally <= onesBump;
      if (onesRun != OR_MAX) onesRun <= onesRun + 1'b1;
    end else if (strobe.tallyZero) begin
      zerosTally <= zerosBump;
      onesRun    <= '0;
      seenZero   <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tagValid <= 1'b0;
      tagData  <= '0;
    end else begin
      tagValid <= strobe.emit;
      if (strobe.emit) tagData <= cycleCount - LATENCY;
    end
  end
endmodule

// File: rtl/beat_crossing_tagger.sv
module beat_crossing_tagger
  import bct_pkg::*;
#(
  parameter int STABLE_LEN     = 16,
  parameter int NO_GLITCH_ONES = 32,
  parameter int TALLY_W        = 8,
  parameter int SYNC_STAGES    = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        beatIn,
  output logic        tagValid,
  output logic [31:0] tagData
);
  logic      sample;
  strobe_t   strobe;
  status_t   stat;
  detState_t state;

  bct_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .dIn  (beatIn),
    .dOut (sample)
  );

  bct_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .sample(sample),
    .stat  (stat),
    .strobe(strobe),
    .state (state)
  );

  bct_datapath #(
    .STABLE_LEN    (STABLE_LEN),
    .NO_GLITCH_ONES(NO_GLITCH_ONES),
    .TALLY_W       (TALLY_W),
    .TAG_W         (32),
    .SYNC_STAGES   (SYNC_STAGES)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .stat    (stat),
    .tagValid(tagValid),
    .tagData (tagData)
  );
endmodule

// File: rtl/bct_checker.sv
module bct_checker #(
  parameter int SYNC_STAGES = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        beatIn,
  input logic        sample,
  input logic        tagValid,
  input logic [31:0] tagData
);
  // R6: the strobe lasts one cycle
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tagValid |=> !tagValid);

  // R6: the bus moves only together with the strobe
  p_tag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tagValid |-> $stable(tagData));

  // R3: a crossing is declared only on a one-sample seen by the detector
  p_decide_on_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tagValid |-> $past(sample));

  // R5: the raw bit one latency earlier was high
  p_raw_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tagValid |-> $past(beatIn, SYNC_STAGES + 1));
endmodule

bind beat_crossing_tagger bct_checker #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .beatIn  (beatIn),
  .sample  (sample),
  .tagValid(tagValid),
  .tagData (tagData)
);

// File: tb/beat_crossing_tagger_test.sv
module beat_crossing_tagger_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        beatIn = 1'b0;
  logic        tagValid;
  logic [31:0] tagData;

  int checks = 0;
  int errors = 0;
  int nTags = 0;
  logic [31:0] tags [0:15];
  logic prevValid = 1'b0;
  bit done = 1'b0;

  beat_crossing_tagger uut (
    .clk(clk), .rst_n(rst_n), .beatIn(beatIn),
    .tagValid(tagValid), .tagData(tagData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // capture strobes; R6 pulse width watched here
  always @(negedge clk) begin
    if (rst_n && tagValid) begin
      if (nTags < 16) tags[nTags] = tagData;
      nTags = nTags + 1;
    end
    if (rst_n && tagValid && prevValid) begin
      errors = errors + 1;
      $display("FAIL R6 strobe wider than one cycle actual=2+ expected=1");
    end
    prevValid = rst_n && tagValid;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reset; returns at the falling edge that starts cycle 0
  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    beatIn = 1'b0;
    repeat (3) @(negedge clk);
    nTags = 0;
    rst_n = 1'b1;
  endtask

  task automatic drv(input logic v);
    beatIn = v;
    @(negedge clk);
  endtask

  task automatic run(input logic v, input int n);
    for (int i = 0; i < n; i++) drv(v);
  endtask

  task automatic pat(input logic [31:0] p, input int n);
    for (int i = 0; i < n; i++) drv(p[i]);
  endtask

  task automatic testReset();
    doReset();
    check(tagValid == 1'b0, "R1 valid after reset", tagValid, 0);
    check(tagData == 32'd0, "R1 data after reset", tagData, 0);
  endtask

  task automatic testClean();
    doReset();
    run(1'b0, 20);          // cycles 0..19
    run(1'b1, 40);          // 20..59, 32nd one at 51
    run(1'b1, 8);
    check(nTags == 1, "R4 clean edge tag count", nTags, 1);
    check(tags[0] == 32'd51, "R4 R5 R9 clean edge tag", tags[0], 51);
  endtask

  task automatic testDefer();
    doReset();
    run(1'b0, 20);
    pat(32'b1011, 4);       // 1,1,0,1 at 20..23
    run(1'b1, 20);
    run(1'b0, 20);
    check(nTags == 1, "R3 deferral tag count", nTags, 1);
    check(tags[0] == 32'd23, "R3 deferred vote tag", tags[0], 23);
  endtask

  task automatic testGlitch();
    doReset();
    run(1'b0, 20);
    pat(32'b1101001, 7);    // 1,0,0,1,0,1,1 at 20..26
    run(1'b1, 20);          // 27..46
    pat(32'b1010, 4);       // falling burst 47..50
    run(1'b0, 20);          // 51..70
    pat(32'b101, 3);        // 71..73
    run(1'b1, 20);
    check(nTags == 2, "R7 falling burst gives no tag", nTags, 2);
    check(tags[0] == 32'd26, "R3 vote tag first burst", tags[0], 26);
    check(tags[1] == 32'd73, "R3 vote tag second burst", tags[1], 73);
    check(tagData == 32'd73, "R6 data held after strobe", tagData, 73);
  endtask

  task automatic testRearm();
    doReset();
    run(1'b0, 10);          // too short after reset
    run(1'b1, 3);
    run(1'b0, 7);           // 13..19, still short
    pat(32'b1011, 4);       // 20..23, must be ignored
    run(1'b0, 8);
    check(nTags == 0, "R2 short low run no tag", nTags, 0);
    doReset();
    run(1'b0, 20);
    run(1'b1, 60);          // tag at 51
    run(1'b0, 10);          // 80..89 short low
    run(1'b1, 40);          // 90..129 ignored
    run(1'b0, 20);          // 130..149
    run(1'b1, 40);          // 150..189, tag at 181
    run(1'b1, 8);
    check(nTags == 2, "R7 short low after high no tag", nTags, 2);
    check(tags[0] == 32'd51, "R7 first tag", tags[0], 51);
    check(tags[1] == 32'd181, "R7 re-armed tag", tags[1], 181);
  endtask

  task automatic testSaturate();
    doReset();
    run(1'b0, 20);
    drv(1'b1);              // 20
    run(1'b0, 270);         // 21..290, zeros tally saturates at 255
    run(1'b1, 40);          // 291..330, limit at 322 (wrapped tally would give 304)
    run(1'b1, 8);
    check(nTags == 1, "R8 saturation tag count", nTags, 1);
    check(tags[0] == 32'd322, "R8 saturated tally tag", tags[0], 322);
  endtask

  initial begin
    testReset();
    testClean();
    testDefer();
    testGlitch();
    testRearm();
    testSaturate();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule